// File: doc/BRIEF.md
# Power-On Strap Capture and Frequency Code Select

This block sits between a set of shared board pins and the frequency synthesizer control. During power-on reset it samples five frequency-select pins and one output-rate select pin. The values are kept in an internal latch in inverted form. When reset is released the latch freezes. One cycle later the block asserts an output-enable, so the same pins can start driving buffered clocks.

After reset the block drives the active 5-bit frequency code. A mode input picks where the code comes from. With the mode input low, the code is the captured pin levels. With it high, the code is a value written by software into a register field elsewhere. The code is registered, so a change of mode or of the software value takes effect at a clock edge and never mid-cycle.

The block also drives a 24/48 MHz rate select taken from the captured rate pin. It exposes the inverted latch contents as status bits that a serial readback path can report.

Top module: `strap_select`

## Requirements
- R1: At every clock edge where `rst_n_i` is sampled low, the latch loads the inverted pin levels. After that edge, `strap_status_o[k]` equals the inverse of `fs_pins_i[k]` for k = 0..4, and `strap_status_o[5]` equals the inverse of `rate_pin_i`.
- R2: The first edge with `rst_n_i` sampled high freezes the latch. Pin changes after that point alter neither `strap_status_o`, `freq_code_o` (in strap mode) nor `rate_sel_o` until the next reset.
- R3: `pin_oe_o` is 0 after every reset edge and after the freeze edge. It is 1 from the second edge after reset release onward.
- R4: The status bit order is fixed as FS0..FS4 in bits 0..4 and the rate pin in bit 5, each stored inverted. A readback decoder relies on this order.
- R5: With `soft_mode_i` = 0 (strap source) outside reset, `freq_code_o` after an edge equals the captured pin levels, not inverted.
- R6: With `soft_mode_i` = 1 (software source) outside reset, `freq_code_o` after an edge equals `soft_code_i` as sampled at that edge. A change to the mode or the code shows only after the next edge.
- R7: At every edge in reset, `freq_code_o` takes the current pin levels, whatever `soft_mode_i` is, so the power-up default is the strap source.
- R8: `rate_sel_o` equals the captured rate pin level, with 0 meaning 48 MHz and 1 meaning 24 MHz. It follows the pin during reset and does not depend on `soft_mode_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_n_i | input | 1 | Power-on reset, active low, sampled at the clock edge |
| fs_pins_i | input | 5 | Raw levels of the five frequency-select pins |
| rate_pin_i | input | 1 | Raw level of the 24/48 MHz select pin |
| soft_mode_i | input | 1 | Code source: 0 = captured straps, 1 = software code |
| soft_code_i | input | 5 | Software-written frequency code |
| freq_code_o | output | 5 | Active frequency code |
| rate_sel_o | output | 1 | 0 = 48 MHz, 1 = 24 MHz |
| strap_status_o | output | 6 | Inverted latched straps for readback |
| pin_oe_o | output | 1 | Output-enable for the shared pins |

## Verification
A corrupted latch shows up on `strap_status_o` right after the edge that corrupted it. In strap mode it also shows on `freq_code_o` one edge later. A wrong enable sequence makes `pin_oe_o` rise at the freeze edge or never rise, which the model sees within two cycles of reset release. A wrong source select, or a missing output register, puts the wrong code on `freq_code_o` at the first edge after a mode or code change. The bench compares every output against the model after each edge, so any of these faults is reported in the cycle it first appears.

// File: rtl/strap_select_pkg.sv
package strap_select_pkg;
    localparam int unsigned FS_BITS = 5;

    typedef enum logic {
        SRC_STRAP = 1'b0,
        SRC_SOFT  = 1'b1
    } code_src_e;
endpackage

// File: rtl/strap_capture.sv
module strap_capture #(
    parameter int unsigned W = 5
) (
    input  logic         clk_i,
    input  logic         rst_n_i,
    input  logic [W:0]   raw_i,
    output logic [W:0]   latch_inv_o,
    output logic         held_o
);
    typedef struct packed {
        logic [W:0] latch;
        logic       held;
    } cap_st_t;

    cap_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!rst_n_i) begin
            st_d.latch = ~raw_i;
            st_d.held  = 1'b0;
        end else begin
            st_d.held  = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign latch_inv_o = st_q.latch;
    assign held_o      = st_q.held;

    // Once frozen, the latch must not move while reset stays released (R2)
    assert_latch_frozen_R2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        st_q.held |=> $stable(st_q.latch));
endmodule

// File: rtl/pin_enable_seq.sv
module pin_enable_seq (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic held_i,
    output logic oe_o
);
    typedef struct packed {
        logic oe;
    } seq_st_t;

    seq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!rst_n_i) begin
            st_d.oe = 1'b0;
        end else begin
            st_d.oe = held_i;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign oe_o = st_q.oe;

    // Drive enable only after the latch is frozen (R3)
    assert_oe_after_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        st_q.oe |-> held_i);
    // Enable follows the freeze by exactly one edge (R3)
    assert_oe_follows_R3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        held_i |=> st_q.oe);
endmodule

// File: rtl/code_source_mux.sv
module code_source_mux
    import strap_select_pkg::*;
#(
    parameter int unsigned W = 5
) (
    input  logic         clk_i,
    input  logic         rst_n_i,
    input  logic [W:0]   raw_i,
    input  logic [W:0]   latch_inv_i,
    input  logic         soft_mode_i,
    input  logic [W-1:0] soft_code_i,
    output logic [W-1:0] code_o,
    output logic         rate_o
);
    typedef struct packed {
        logic [W-1:0] code;
        logic         rate;
    } mux_st_t;

    mux_st_t   st_d, st_q;
    code_src_e src;

    always_comb begin
        src  = soft_mode_i ? SRC_SOFT : SRC_STRAP;
        st_d = st_q;
        if (!rst_n_i) begin
            st_d.code = raw_i[W-1:0];
            st_d.rate = raw_i[W];
        end else begin
            st_d.rate = ~latch_inv_i[W];
            if (src == SRC_SOFT) begin
                st_d.code = soft_code_i;
            end else begin
                st_d.code = ~latch_inv_i[W-1:0];
            end
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign code_o = st_q.code;
    assign rate_o = st_q.rate;

    // Software source reaches the output one edge later (R6)
    assert_soft_path_R6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        soft_mode_i |=> (st_q.code == $past(soft_code_i)));
    // Strap source presents the re-inverted latch (R5)
    assert_strap_path_R5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !soft_mode_i |=> (st_q.code == ~$past(latch_inv_i[W-1:0])));
    // Rate select holds once out of reset, whatever the mode (R8)
    assert_rate_steady_R8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $past(rst_n_i) |=> $stable(st_q.rate));
endmodule

// File: rtl/strap_select.sv
module strap_select
    import strap_select_pkg::*;
#(
    parameter int unsigned W = FS_BITS
) (
    input  logic         clk_i,
    input  logic         rst_n_i,
    input  logic [W-1:0] fs_pins_i,
    input  logic         rate_pin_i,
    input  logic         soft_mode_i,
    input  logic [W-1:0] soft_code_i,
    output logic [W-1:0] freq_code_o,
    output logic         rate_sel_o,
    output logic [W:0]   strap_status_o,
    output logic         pin_oe_o
);
    logic [W:0] raw;
    logic [W:0] latch_inv;
    logic       held;

    assign raw = {rate_pin_i, fs_pins_i};

    strap_capture #(.W(W)) u_capture (
        .clk_i       (clk_i),
        .rst_n_i     (rst_n_i),
        .raw_i       (raw),
        .latch_inv_o (latch_inv),
        .held_o      (held)
    );

    pin_enable_seq u_enable (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .held_i  (held),
        .oe_o    (pin_oe_o)
    );

    code_source_mux #(.W(W)) u_mux (
        .clk_i       (clk_i),
        .rst_n_i     (rst_n_i),
        .raw_i       (raw),
        .latch_inv_i (latch_inv),
        .soft_mode_i (soft_mode_i),
        .soft_code_i (soft_code_i),
        .code_o      (freq_code_o),
        .rate_o      (rate_sel_o)
    );

    assign strap_status_o = latch_inv;

    // Pins are never driven while the status can still change (R1)
    assert_no_drive_in_reset_R1: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        pin_oe_o |=> $stable(strap_status_o));
endmodule

// File: tb/strap_select_test.sv
module strap_select_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] fs = 5'b10110;
    logic       rp = 1'b1;
    logic       mode = 1'b0;
    logic [4:0] sw = 5'b00000;
    logic [4:0] code;
    logic       rate;
    logic [5:0] status;
    logic       oe;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // behavioural model
    logic [4:0] m_cap;
    logic       m_rate;
    logic [4:0] m_code;
    int         m_since = 0;
    bit         m_valid = 0;
    string      m_tag = "R7";

    always #2 clk = ~clk;

    strap_select uut (
        .clk_i(clk), .rst_n_i(rst_n), .fs_pins_i(fs), .rate_pin_i(rp),
        .soft_mode_i(mode), .soft_code_i(sw), .freq_code_o(code),
        .rate_sel_o(rate), .strap_status_o(status), .pin_oe_o(oe)
    );

    always @(posedge clk) begin
        m_valid = 1;
        if (!rst_n) begin
            m_cap   = fs;
            m_rate  = rp;
            m_code  = fs;
            m_since = 0;
            m_tag   = "R7";
        end else begin
            m_since = m_since + 1;
            if (mode) begin
                m_code = sw;
                m_tag  = "R6";
            end else begin
                m_code = m_cap;
                m_tag  = "R5";
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        if (m_valid) begin
            check("R4 status", status, {~m_rate, ~m_cap});
            check(m_tag, code, m_code);
            check("R8 rate", rate, m_rate);
            check("R3 oe", oe, (m_since >= 2) ? 1 : 0);
        end
    endtask

    initial begin
        tick();
        tick();
        // R1: capture follows pins while in reset
        fs = 5'b01101; rp = 1'b0; mode = 1'b1; sw = 5'b11100;
        tick();
        check("R1 capture", status, {1'b1, 5'b10010});
        check("R7 code in reset", code, 5'b01101);
        // release reset
        rst_n = 1'b1;
        tick();
        check("R3 oe low at freeze", oe, 0);
        check("R6 soft code", code, 5'b11100);
        fs = 5'b11111; rp = 1'b1;
        tick();
        check("R3 oe high", oe, 1);
        check("R2 status frozen", status, {1'b1, 5'b10010});
        mode = 1'b0;
        tick();
        check("R5 strap code", code, 5'b01101);
        check("R8 rate 48MHz", rate, 0);
        for (int i = 0; i < 8; i++) begin
            mode = i[0];
            sw   = 5'(i * 7 + 3);
            fs   = 5'(i * 5);
            tick();
        end
        mode = 1'b0;
        tick();
        check("R2 strap unaffected", code, 5'b01101);
        // second reset with software mode high
        rst_n = 1'b0; mode = 1'b1; fs = 5'b00000; rp = 1'b1; sw = 5'b10101;
        tick();
        check("R7 default source", code, 5'b00000);
        check("R3 oe drops", oe, 0);
        tick();
        rst_n = 1'b1;
        tick();
        tick();
        mode = 1'b0;
        tick();
        check("R5 strap zero", code, 5'b00000);
        check("R8 rate 24MHz", rate, 1);
        check("R4 status order", status, 6'b011111);
        for (int i = 0; i < 6; i++) begin
            sw = 5'(31 - i); mode = 1'b1;
            tick();
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule